// File: doc/BRIEF.md
# Serial Transceiver with Data-Logic and Line-Polarity Inversion

This block is an asynchronous serial transmitter and receiver pair. A host writes a byte with a one-cycle strobe, and the transmitter sends it as a framed character on its output pin. The receiver watches its input pin, rebuilds characters, and presents each byte with a one-cycle valid pulse and a parity-error flag. The bit period is an internal divider: `CLK_DIV` system clocks make one sixteenth of a bit.

Two inversion controls act independently. The data-logic reverse control complements only the eight payload bits. It acts as the byte is taken in for sending and again as a received byte is handed back, so a byte makes the round trip unchanged. The line-polarity control complements every level on both pins, including idle, start, parity and stop. The frame can carry the payload least or most significant bit first, can carry an optional parity bit of either sense, and can end in one or two stop bits. The frame latches every mode input when it starts, so changing a mode input during a character does not affect the character in progress.

Top module: `uart_invert`

## Requirements
- R1: With `cfg_dlrev`=1, each payload bit on the line is the complement of the written bit, and the receiver complements received payload bits again, so a byte sent through a loopback returns equal to the byte written.
- R2: With `cfg_dlrev`=0, the payload bits on the line equal the written bits and the received byte equals the line payload.
- R3: With `cfg_iopol`=1, every bit on `txd` is the complement of its level with `cfg_iopol`=0, and `rxd` is complemented before the receiver decodes it.
- R4: The frame goes out in this order: one start bit, eight payload bits, the parity bit when `cfg_par_en`=1, then the stop bits. Each bit lasts 16*`CLK_DIV` clocks.
- R5: With `cfg_msb`=0 the payload goes out bit 0 first. With `cfg_msb`=1 it goes out bit 7 first. The receiver reassembles the byte with the same order.
- R6: With `cfg_stop2`=0 the frame carries one stop bit, and with `cfg_stop2`=1 it carries two. The stop level is the idle level.
- R7: With `cfg_iopol`=0 the idle level on `txd` is 1 and the start level is 0. With `cfg_iopol`=1 both levels are reversed.
- R8: The parity bit is the XOR of the eight line payload bits, complemented when `cfg_par_odd`=1. `rx_perr` is 1 with a received byte whose parity bit disagrees, and is 0 when parity is disabled.
- R9: `tx_busy` rises in the cycle after an accepted `tx_wr` and falls exactly (10 + parity + extra stop)*16*`CLK_DIV` clocks after it rose. A `tx_wr` while `tx_busy`=1 is ignored.
- R10: `rx_valid` is a single-cycle pulse issued once the stop bit has been sampled. `rx_data` and `rx_perr` change only together with that pulse.
- R11: The transmitter and receiver each latch the mode inputs when a frame starts, so a change to any mode input in mid-frame leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dlrev | input | 1 | Payload-bit inversion enable |
| cfg_iopol | input | 1 | Whole-line polarity inversion on both pins |
| cfg_msb | input | 1 | 1: payload most significant bit first |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | 1: parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter frame in progress |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| rx_valid | output | 1 | One-cycle pulse: new received byte |
| rx_data | output | 8 | Last received byte |
| rx_perr | output | 1 | Parity error for the last received byte |

## Verification
The bench loops the output pin back to the input and runs all 32 combinations of the five frame-shape controls. It checks every line bit at mid-bit against a frame it builds itself. It also checks that each byte comes back through a queue. If the two inversion stages were swapped or merged, the start, stop and idle levels would be wrong under data-logic reverse. A receiver that skipped its own complement would return inverted bytes. In some frames the bench flips the order, stop-count, parity and data-reverse controls halfway through, and it issues a second write while the transmitter is busy. A design that failed to latch its modes at frame start, or that accepted a write while busy, would send a broken frame or an extra byte. The bench also drives hand-built frames with bad and good parity of both senses to expose a wrong parity sense or a missing error flag.

// File: rtl/uart_invert.sv
module uart_invert #(
  parameter int CLK_DIV = 4,
  parameter int OSR     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dlrev,
  input  logic       cfg_iopol,
  input  logic       cfg_msb,
  input  logic       cfg_stop2,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_perr
);
  localparam int BIT_CYC = CLK_DIV * OSR;
  localparam int CW      = $clog2(BIT_CYC);
  localparam int DIVW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PW      = $clog2(OSR);
  localparam int HALF    = OSR / 2;

  function automatic logic [7:0] flip8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) flip8[i] = v[7-i];
  endfunction

  // transmitter
  logic [7:0]    tx_word, tx_ord;
  logic          tx_par, tx_pol;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [CW-1:0] tx_cnt;

  assign tx_word = cfg_dlrev ? ~tx_data : tx_data;
  assign tx_ord  = cfg_msb ? flip8(tx_word) : tx_word;
  assign tx_par  = (^tx_word) ^ cfg_par_odd;
  assign txd     = tx_busy ? (tx_sh[0] ^ tx_pol) : ~cfg_iopol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_pol  <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (!tx_busy) begin
      if (tx_wr) begin
        tx_busy <= 1'b1;
        tx_pol  <= cfg_iopol;
        tx_cnt  <= '0;
        tx_sh   <= cfg_par_en ? {2'b11, tx_par, tx_ord, 1'b0} : {3'b111, tx_ord, 1'b0};
        tx_left <= 4'(10 + int'(cfg_par_en) + int'(cfg_stop2));
      end
    end else if (tx_cnt == CW'(BIT_CYC - 1)) begin
      tx_cnt  <= '0;
      tx_sh   <= {1'b1, tx_sh[11:1]};
      tx_left <= tx_left - 4'd1;
      if (tx_left == 4'd1) tx_busy <= 1'b0;
    end else begin
      tx_cnt <= tx_cnt + CW'(1);
    end
  end

  // receiver
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_t;
  rx_st_t          rx_st;
  logic [1:0]      rx_sync;
  logic [DIVW-1:0] rdiv;
  logic [PW-1:0]   ph;
  logic [2:0]      bitn;
  logic [7:0]      rsh;
  logic            rpar, r_pol, r_msb, r_par_en, r_odd, r_dl;
  logic            tick, rin, at_end;

  assign tick   = (rdiv == DIVW'(CLK_DIV - 1));
  assign rin    = rx_sync[1] ^ ((rx_st == RX_IDLE) ? cfg_iopol : r_pol);
  assign at_end = tick && (ph == PW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      rdiv     <= '0;
      rx_st    <= RX_IDLE;
      ph       <= '0;
      bitn     <= '0;
      rsh      <= '0;
      rpar     <= 1'b0;
      r_pol    <= 1'b0;
      r_msb    <= 1'b0;
      r_par_en <= 1'b0;
      r_odd    <= 1'b0;
      r_dl     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
    end else begin
      rx_sync  <= {rx_sync[0], rxd};
      rdiv     <= tick ? '0 : rdiv + DIVW'(1);
      rx_valid <= 1'b0;
      if (tick && rx_st != RX_IDLE) ph <= ph + PW'(1);
      unique case (rx_st)
        RX_IDLE: if (tick && !rin) begin
          rx_st    <= RX_START;
          ph       <= '0;
          r_pol    <= cfg_iopol;
          r_msb    <= cfg_msb;
          r_par_en <= cfg_par_en;
          r_odd    <= cfg_par_odd;
          r_dl     <= cfg_dlrev;
        end
        RX_START: if (tick && ph == PW'(HALF - 1)) begin
          ph    <= '0;
          bitn  <= '0;
          rx_st <= rin ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (at_end) begin
          rsh  <= r_msb ? {rsh[6:0], rin} : {rin, rsh[7:1]};
          bitn <= bitn + 3'd1;
          if (bitn == 3'd7) rx_st <= r_par_en ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (at_end) begin
          rpar  <= rin;
          rx_st <= RX_STOP;
        end
        RX_STOP: if (at_end) begin
          rx_valid <= 1'b1;
          rx_data  <= r_dl ? ~rsh : rsh;
          rx_perr  <= r_par_en & ((^rsh) ^ rpar ^ r_odd);
          rx_st    <= RX_IDLE;
        end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  AST_WR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tx_wr && !tx_busy |=> tx_busy); // R9
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> txd == $past(cfg_iopol)); // R7
  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) tx_busy && tx_left == 4'd1 |-> txd != tx_pol); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |-> $stable(rx_data) && $stable(rx_perr)); // R10
  AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !r_par_en |-> !rx_perr); // R8
endmodule

// File: tb/uart_invert_bench.sv
module uart_invert_bench;
  localparam int CLK_DIV = 4;
  localparam int BC = CLK_DIV * 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_dl = 0, c_pol = 0, c_msb = 0, c_s2 = 0, c_pe = 0, c_odd = 0;
  logic tx_wr = 0;
  logic [7:0] tx_data = '0;
  logic tx_busy, txd, rx_valid, rx_perr;
  logic [7:0] rx_data;
  logic inj = 0, inj_line = 1;
  logic rxd;
  int tests = 0, fails = 0;
  logic [8:0] q[$];

  always #10 clk = ~clk;
  assign rxd = inj ? inj_line : txd;

  uart_invert #(.CLK_DIV(CLK_DIV)) u_uart_invert (
    .clk(clk), .rst_n(rst_n), .cfg_dlrev(c_dl), .cfg_iopol(c_pol), .cfg_msb(c_msb),
    .cfg_stop2(c_s2), .cfg_par_en(c_pe), .cfg_par_odd(c_odd), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rx_valid) begin
    if (q.size() == 0) check(0, "R10 unexpected rx_valid", int'(rx_data), 0);
    else begin
      logic [8:0] e;
      e = q.pop_front();
      check({rx_perr, rx_data} == e, "R1 R2 R8 R10 received byte", int'({rx_perr, rx_data}), int'(e));
    end
  end

  task automatic send(input logic [7:0] b, input bit disturb);
    logic [7:0] d;
    logic [11:0] fr;
    int n;
    d = c_dl ? ~b : b;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++) fr[1+i] = c_msb ? d[7-i] : d[i];
    fr[9] = c_pe ? ((^d) ^ c_odd) : 1'b1;
    fr[10] = 1'b1;
    fr[11] = 1'b1;
    n = 10 + int'(c_pe) + int'(c_s2);
    q.push_back({1'b0, b});
    check(txd == ~c_pol, "R7 idle level", int'(txd), int'(~c_pol));
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (BC/2 - 1) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      string tag;
      if (i == 0) tag = "R7 R3 start bit";
      else if (i < 9) tag = c_dl ? "R1 R4 R5 data bit" : "R2 R4 R5 data bit";
      else if (i == 9 && c_pe) tag = "R8 R3 parity bit";
      else tag = "R6 R3 stop bit";
      check(txd == (fr[i] ^ c_pol), tag, int'(txd), int'(fr[i] ^ c_pol));
      if (i < n - 1) begin
        if (disturb && i == 3) begin
          c_dl = ~c_dl; c_msb = ~c_msb; c_s2 = ~c_s2; c_pe = ~c_pe; c_odd = ~c_odd;
          tx_wr = 1'b1; tx_data = ~b;
          @(negedge clk); tx_wr = 1'b0;
          repeat (BC - 1) @(negedge clk);
        end else repeat (BC) @(negedge clk);
      end
    end
    repeat (BC/2) @(negedge clk);
    check(tx_busy == 1'b1, "R9 busy through last stop", int'(tx_busy), 1);
    @(negedge clk);
    check(tx_busy == 1'b0, "R9 busy falls at frame end", int'(tx_busy), 0);
    if (disturb) begin
      c_dl = ~c_dl; c_msb = ~c_msb; c_s2 = ~c_s2; c_pe = ~c_pe; c_odd = ~c_odd;
    end
    repeat (BC) @(negedge clk);
  endtask

  task automatic inject(input logic [7:0] b, input logic pbit, input logic exp_perr);
    logic [10:0] fr;
    fr = {1'b1, pbit, b, 1'b0};
    q.push_back({exp_perr, b});
    @(negedge clk); inj = 1'b1;
    for (int i = 0; i < 11; i++) begin
      inj_line = fr[i];
      repeat (BC) @(negedge clk);
    end
    inj_line = 1'b1;
    repeat (BC) @(negedge clk);
    inj = 1'b0;
    repeat (BC) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(txd == 1'b1 && tx_busy == 1'b0, "R7 R9 reset line state", int'({tx_busy, txd}), 1);
    check(rx_valid == 1'b0 && rx_data == 8'h00 && rx_perr == 1'b0, "R10 reset rx state",
          int'({rx_valid, rx_perr, rx_data}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int m = 0; m < 32; m++) begin
      {c_pol, c_dl, c_msb, c_s2, c_pe} = 5'(m);
      c_odd = m[1] ^ m[3];
      repeat (2 * BC) @(negedge clk);
      send(8'((m * 37 + 11) & 8'hff), 1'b0);
      send(8'((m * 91 + 200) & 8'hff), m[0] ^ m[2]);
    end
    {c_pol, c_dl, c_msb, c_s2, c_pe, c_odd} = 6'b000010;
    repeat (2 * BC) @(negedge clk);
    inject(8'hA5, 1'b1, 1'b1);   // R8 even parity, bad parity bit
    inject(8'h3C, 1'b0, 1'b0);   // R8 even parity, good
    c_odd = 1'b1;
    inject(8'h01, 1'b0, 1'b0);   // R8 odd parity, good
    inject(8'h01, 1'b1, 1'b1);   // R8 odd parity, bad
    repeat (2 * BC) @(negedge clk);
    check(q.size() == 0, "R9 R11 every byte returned once", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule